// File: doc/BRIEF.md
# Pattern-Table Bank Mapper with Fetch-Triggered Latches

This block sits between a picture processor's 8 KiB pattern-table address space and a larger character ROM or RAM. It holds eight 16-bit bank registers. Each register is loaded one byte at a time: a low-byte write and a high-byte write, both addressed by a 3-bit register number. A two-bit granularity selector divides the 8 KiB window into one 8 KiB page, two 4 KiB pages, four 2 KiB pages or eight 1 KiB pages. Each page draws its bank number from a fixed register. An outer AND mask and an outer OR mask, both counted in 1 KiB units, are scaled to the active page size and then applied to the bank number.

When the 4 KiB granularity is active and the latch-mode input is high, each 4 KiB half picks its register from a 2-bit latch. Tile fetches from certain addresses load that latch. The output address is the masked bank number joined to the low picture-processor address bits inside the page. A write-enable towards character RAM follows the picture-processor write strobe unless the write-protect input is high.

The block holds only the bank registers and the two latches. Granularity, latch mode, write protect and the masks come in as steady inputs from the surrounding mapper. Translation is combinational on the current state. Register writes and latch loads take effect on the next clock edge.

Top module: `chr_bank_mapper`

## Requirements
- R1: After reset all eight bank registers and both latches are zero, so with 1 KiB granularity `chr_addr` equals `ppu_addr[9:0]`.
- R2: A clock edge with `reg_wr`=1 and `reg_hi`=0 replaces bits [7:0] of register `reg_sel` with `reg_data` and keeps bits [15:8].
- R3: A clock edge with `reg_wr`=1 and `reg_hi`=1 replaces bits [15:8] of register `reg_sel` with `reg_data` and keeps bits [7:0].
- R4: With `gran_sel`=0 (8 KiB), `chr_addr` = {(reg0 & (and_mask>>3)) | (or_mask>>3), ppu_addr[12:0]}, truncated to 26 bits.
- R5: With `gran_sel`=1 (4 KiB) and `latch_mode`=0, the half chosen by `ppu_addr[12]` uses register 0 or 4. The masks are shifted right by 2, and the offset is `ppu_addr[11:0]`.
- R6: With `gran_sel`=2 (2 KiB), the page `ppu_addr[12:11]` uses register 2×page. The masks are shifted right by 1, and the offset is `ppu_addr[10:0]`.
- R7: With `gran_sel`=3 (1 KiB), page `ppu_addr[12:10]` uses the register of the same number. The masks are not shifted, and the offset is `ppu_addr[9:0]`.
- R8: With `gran_sel`=1 and `latch_mode`=1, half h (h = `ppu_addr[12]`) uses register (latch[h] & 2) | 4h.
- R9: A clock edge with `ppu_rd`=1 loads the latches as follows:
  - address exactly 0x0FD8 sets latch 0 to 0;
  - address exactly 0x0FE8 sets latch 0 to 2;
  - any address 0x1FD8–0x1FDF sets latch 1 to 0;
  - any address 0x1FE8–0x1FEF sets latch 1 to 2.

  Other addresses leave the latches unchanged. The fetch that loads a latch is itself translated with the old latch value.
- R10: `latch_mode` has no effect on `chr_addr` when `gran_sel` is not 1.
- R11: `chr_we` = `ppu_wr` when `ram_wprot`=0, and `chr_we` is 0 when `ram_wprot`=1.
- R12: In a cycle where a register write and a fetch happen together, the fetch is translated with the register's old value. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Bank register byte write strobe |
| reg_hi | input | 1 | 1 selects bits [15:8], 0 selects bits [7:0] |
| reg_sel | input | 3 | Bank register number |
| reg_data | input | 8 | Byte to write |
| gran_sel | input | 2 | Page granularity: 0=8K, 1=4K, 2=2K, 3=1K |
| latch_mode | input | 1 | Latch-switched register choice in 4 KiB granularity |
| ram_wprot | input | 1 | Blocks character RAM writes |
| and_mask | input | 16 | Outer bank AND mask in 1 KiB units |
| or_mask | input | 16 | Outer bank OR mask in 1 KiB units |
| ppu_addr | input | 13 | Pattern-table address |
| ppu_rd | input | 1 | Fetch strobe (drives latch loading) |
| ppu_wr | input | 1 | Pattern-table write strobe |
| chr_addr | output | 26 | Translated character memory address |
| chr_we | output | 1 | Character RAM write enable |

## Verification
Two events can land in one cycle: a bank register write, and a fetch that both reads through that register and hits a latch trigger address. The bench provokes this with `latch_mode` on at 4 KiB granularity. It writes register 2 in the same cycle that it fetches from 0x0FD8 while latch 0 holds 2. It then checks that this cycle's address is built from the old contents of register 2. It also checks that the next cycle's address comes from register 0, because the latch has moved to 0. A later fetch that points the latch back at register 2 confirms that the write landed.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
    localparam int NUM_BANK_REGS = 8;
    localparam int REG_SEL_W     = $clog2(NUM_BANK_REGS);
    localparam int PPU_AW        = 13;
    localparam int PAGE_BITS     = 10;

    typedef enum logic [1:0] {
        GRAN_8K = 2'd0,
        GRAN_4K = 2'd1,
        GRAN_2K = 2'd2,
        GRAN_1K = 2'd3
    } gran_e;

    // Latch trigger addresses (half 0 exact, half 1 as 8-byte rows)
    localparam logic [PPU_AW-1:0] TRIG0_LOW  = 13'h0FD8;
    localparam logic [PPU_AW-1:0] TRIG0_HIGH = 13'h0FE8;
    localparam logic [PPU_AW-4:0] TRIG1_LOW  = 10'h3FB;
    localparam logic [PPU_AW-4:0] TRIG1_HIGH = 10'h3FD;
endpackage

// File: rtl/chr_bank_file.sv
module chr_bank_file
    import chr_map_pkg::*;
#(
    parameter int BANK_W = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reg_wr,
    input  logic                                    reg_hi,
    input  logic [REG_SEL_W-1:0]                    reg_sel,
    input  logic [7:0]                              reg_data,
    output logic [NUM_BANK_REGS-1:0][BANK_W-1:0]    bank_q
);
    localparam int HI_W = BANK_W - 8;

    typedef struct packed {
        logic [NUM_BANK_REGS-1:0][BANK_W-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_BANK_REGS; i++) begin
            if (reg_wr && reg_sel == REG_SEL_W'(i)) begin
                if (reg_hi)
                    st_d.bank[i][BANK_W-1:8] = HI_W'(reg_data);
                else
                    st_d.bank[i][7:0] = reg_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bank_q = st_q.bank;
endmodule

// File: rtl/chr_latch_track.sv
module chr_latch_track
    import chr_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [1:0][1:0]   latch_q
);
    typedef struct packed {
        logic [1:0][1:0] lat;
    } latch_state_t;

    latch_state_t st_d, st_q;

    logic hit0_lo, hit0_hi, hit1_lo, hit1_hi;

    always_comb begin
        hit0_lo = ppu_rd && (ppu_addr == TRIG0_LOW);
        hit0_hi = ppu_rd && (ppu_addr == TRIG0_HIGH);
        hit1_lo = ppu_rd && (ppu_addr[PPU_AW-1:3] == TRIG1_LOW);
        hit1_hi = ppu_rd && (ppu_addr[PPU_AW-1:3] == TRIG1_HIGH);

        st_d = st_q;
        if (hit0_lo) st_d.lat[0] = 2'd0;
        if (hit0_hi) st_d.lat[0] = 2'd2;
        if (hit1_lo) st_d.lat[1] = 2'd0;
        if (hit1_hi) st_d.lat[1] = 2'd2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign latch_q = st_q.lat;
endmodule

// File: rtl/chr_addr_xlate.sv
module chr_addr_xlate
    import chr_map_pkg::*;
#(
    parameter int BANK_W = 16,
    localparam int ADDR_W = BANK_W + PAGE_BITS
) (
    input  logic [NUM_BANK_REGS-1:0][BANK_W-1:0] bank_q,
    input  logic [1:0][1:0]                      latch_q,
    input  gran_e                                gran,
    input  logic                                 latch_mode,
    input  logic [BANK_W-1:0]                    and_mask,
    input  logic [BANK_W-1:0]                    or_mask,
    input  logic [PPU_AW-1:0]                    ppu_addr,
    output logic [ADDR_W-1:0]                    chr_addr
);
    logic [REG_SEL_W-1:0] idx;
    int unsigned          shamt;
    logic [BANK_W-1:0]    bank_m;
    logic [PPU_AW-1:0]    keep;
    logic                 half;

    always_comb begin
        half  = ppu_addr[PPU_AW-1];
        idx   = '0;
        shamt = 0;
        unique case (gran)
            GRAN_8K: begin
                idx   = '0;
                shamt = 3;
            end
            GRAN_4K: begin
                idx = {half, 2'b00};
                if (latch_mode)
                    idx[1] = latch_q[half][1];
                shamt = 2;
            end
            GRAN_2K: begin
                idx   = {ppu_addr[PPU_AW-1:PPU_AW-2], 1'b0};
                shamt = 1;
            end
            default: begin
                idx   = ppu_addr[PPU_AW-1:PPU_AW-3];
                shamt = 0;
            end
        endcase

        bank_m   = (bank_q[idx] & (and_mask >> shamt)) | (or_mask >> shamt);
        keep     = PPU_AW'((32'd1 << (PAGE_BITS + shamt)) - 32'd1);
        chr_addr = (ADDR_W'(bank_m) << (PAGE_BITS + shamt))
                 | ADDR_W'(ppu_addr & keep);
    end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
    import chr_map_pkg::*;
#(
    parameter int BANK_W = 16,
    localparam int ADDR_W = BANK_W + PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_hi,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_data,
    input  logic [1:0]        gran_sel,
    input  logic              latch_mode,
    input  logic              ram_wprot,
    input  logic [BANK_W-1:0] and_mask,
    input  logic [BANK_W-1:0] or_mask,
    input  logic [12:0]       ppu_addr,
    input  logic              ppu_rd,
    input  logic              ppu_wr,
    output logic [ADDR_W-1:0] chr_addr,
    output logic              chr_we
);
    logic [NUM_BANK_REGS-1:0][BANK_W-1:0] bank_q;
    logic [1:0][1:0]                      latch_q;

    chr_bank_file #(.BANK_W(BANK_W)) i_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_hi   (reg_hi),
        .reg_sel  (reg_sel),
        .reg_data (reg_data),
        .bank_q   (bank_q)
    );

    chr_latch_track i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .ppu_rd   (ppu_rd),
        .ppu_addr (ppu_addr),
        .latch_q  (latch_q)
    );

    chr_addr_xlate #(.BANK_W(BANK_W)) i_xlate (
        .bank_q     (bank_q),
        .latch_q    (latch_q),
        .gran       (gran_e'(gran_sel)),
        .latch_mode (latch_mode),
        .and_mask   (and_mask),
        .or_mask    (or_mask),
        .ppu_addr   (ppu_addr),
        .chr_addr   (chr_addr)
    );

    assign chr_we = ppu_wr & ~ram_wprot;
endmodule

// File: rtl/chr_bank_mapper_chk.sv
module chr_bank_mapper_chk #(
    parameter int BANK_W = 16,
    localparam int ADDR_W = BANK_W + 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic                   reg_hi,
    input logic [2:0]             reg_sel,
    input logic [7:0]             reg_data,
    input logic [1:0]             gran_sel,
    input logic                   ram_wprot,
    input logic [12:0]            ppu_addr,
    input logic                   ppu_rd,
    input logic [ADDR_W-1:0]      chr_addr,
    input logic                   chr_we,
    input logic [7:0][BANK_W-1:0] bank_q,
    input logic [1:0][1:0]        latch_q
);
    a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_hi |=> bank_q[$past(reg_sel)][7:0] == $past(reg_data));

    a_r3_keep_low: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_hi && reg_sel == 3'd5 |=> $stable(bank_q[5][7:0]));

    a_r4_offset_8k: assert property (@(posedge clk) disable iff (!rst_n)
        gran_sel == 2'd0 |-> chr_addr[12:0] == ppu_addr);

    a_r7_offset_1k: assert property (@(posedge clk) disable iff (!rst_n)
        gran_sel == 2'd3 |-> chr_addr[9:0] == ppu_addr[9:0]);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_rd |=> $stable(latch_q));

    a_r9_clear0: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_rd && ppu_addr == 13'h0FD8 |=> latch_q[0] == 2'd0);

    a_r9_set1: assert property (@(posedge clk) disable iff (!rst_n)
        ppu_rd && ppu_addr[12:3] == 10'h3FD |=> latch_q[1] == 2'd2);

    a_r11_protect: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wprot |-> !chr_we);
endmodule

bind chr_bank_mapper chr_bank_mapper_chk #(.BANK_W(BANK_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_hi    (reg_hi),
    .reg_sel   (reg_sel),
    .reg_data  (reg_data),
    .gran_sel  (gran_sel),
    .ram_wprot (ram_wprot),
    .ppu_addr  (ppu_addr),
    .ppu_rd    (ppu_rd),
    .chr_addr  (chr_addr),
    .chr_we    (chr_we),
    .bank_q    (bank_q),
    .latch_q   (latch_q)
);

// File: tb/test_chr_bank_mapper.sv
`timescale 1ns/1ps
module test_chr_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_hi = 0;
    logic [2:0]  reg_sel = 0;
    logic [7:0]  reg_data = 0;
    logic [1:0]  gran_sel = 0;
    logic        latch_mode = 0, ram_wprot = 0;
    logic [15:0] and_mask = 16'hFFFF, or_mask = 16'h0000;
    logic [12:0] ppu_addr = 0;
    logic        ppu_rd = 0, ppu_wr = 0;
    logic [25:0] chr_addr;
    logic        chr_we;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [15:0] m [8];
    int          lat [2];

    always #2 clk = ~clk;

    chr_bank_mapper i_chr_bank_mapper (.*);

    // {gran[1:0], latch_mode, addr[12:0]}
    localparam logic [15:0] VEC [14] = '{
        {2'd0, 1'b0, 13'h0000}, {2'd0, 1'b0, 13'h1ABC},
        {2'd0, 1'b1, 13'h1FFF},
        {2'd1, 1'b0, 13'h0123}, {2'd1, 1'b0, 13'h1F00},
        {2'd2, 1'b0, 13'h0456}, {2'd2, 1'b0, 13'h0800},
        {2'd2, 1'b0, 13'h1234}, {2'd2, 1'b1, 13'h1FFF},
        {2'd3, 1'b0, 13'h0000}, {2'd3, 1'b0, 13'h05AA},
        {2'd3, 1'b0, 13'h0BCD}, {2'd3, 1'b1, 13'h1400},
        {2'd3, 1'b0, 13'h1FFF}
    };

    function automatic logic [25:0] model(int g, bit le, logic [12:0] a);
        int idx, sh;
        logic [15:0] b;
        longint full;
        case (g)
            0: begin idx = 0; sh = 3; end
            1: begin
                idx = a[12] ? 4 : 0;
                if (le) idx = idx + (lat[a[12]] & 2);
                sh = 2;
            end
            2: begin idx = 2 * int'(a[12:11]); sh = 1; end
            default: begin idx = int'(a[12:10]); sh = 0; end
        endcase
        b = (m[idx] & (and_mask >> sh)) | (or_mask >> sh);
        full = (longint'(b) * (longint'(1) << (10 + sh))) + (longint'(a) % (longint'(1) << (10 + sh)));
        return full[25:0];
    endfunction

    task automatic chk(string tag, logic [25:0] got, logic [25:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(bit hi, int idx, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_hi = hi; reg_sel = 3'(idx); reg_data = d;
        @(negedge clk);
        reg_wr = 0;
        if (hi) m[idx][15:8] = d; else m[idx][7:0] = d;
    endtask

    task automatic fetch(logic [12:0] a);
        @(negedge clk);
        ppu_rd = 1; ppu_addr = a;
        @(negedge clk);
        ppu_rd = 0;
        if (a == 13'h0FD8) lat[0] = 0;
        if (a == 13'h0FE8) lat[0] = 2;
        if (a >= 13'h1FD8 && a <= 13'h1FDF) lat[1] = 0;
        if (a >= 13'h1FE8 && a <= 13'h1FEF) lat[1] = 2;
    endtask

    task automatic look(string tag, int g, bit le, logic [12:0] a);
        @(negedge clk);
        gran_sel = 2'(g); latch_mode = le; ppu_addr = a;
        #1;
        chk(tag, chr_addr, model(g, le, a));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'h0;
        lat[0] = 0; lat[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        look("R1 reset 1K", 3, 0, 13'h1C05);
        chk("R1 reset direct", chr_addr, 26'h005);

        // R2/R3 byte writes
        for (int i = 0; i < 8; i++) wr(0, i, 8'(8'h11 * (i + 1) + 8'h01));
        wr(1, 5, 8'hA5);
        wr(0, 5, 8'h3C);
        look("R3 high kept after low write", 3, 0, 13'h1400);
        chk("R2 low byte", chr_addr, 26'(16'hA53C) << 10);
        wr(1, 0, 8'h01);
        wr(1, 6, 8'hFF);
        look("R3 high byte r6", 3, 0, 13'h1801);

        // R4..R7, R10 table walk
        foreach (VEC[k]) begin
            look($sformatf("R4-7/R10 vec%0d gran%0d", k, int'(VEC[k][15:14])),
                 int'(VEC[k][15:14]), VEC[k][13], VEC[k][12:0]);
        end
        look("R10 latch ignored 1K", 3, 1, 13'h0801);
        chk("R10 1K value", chr_addr, (26'(m[2]) << 10) | 26'h001);

        // R8/R9 latch behaviour
        look("R8 latch0 zero", 1, 1, 13'h0123);
        fetch(13'h0FE8);
        look("R8 latch0=2 -> r2", 1, 1, 13'h0123);
        chk("R8 r2 value", chr_addr, (26'(m[2]) << 12) | 26'h123);
        look("R5 latch off still r0", 1, 0, 13'h0123);
        fetch(13'h0FD9);
        look("R9 near miss half0", 1, 1, 13'h0777);
        fetch(13'h1FEB);
        look("R9 half1 set -> r6", 1, 1, 13'h1ABC);
        chk("R9 r6 value", chr_addr, (26'(m[6]) << 12) | 26'hABC);
        fetch(13'h1FF0);
        look("R9 half1 miss", 1, 1, 13'h1ABC);
        fetch(13'h1FDF);
        look("R9 half1 clear -> r4", 1, 1, 13'h1ABC);
        look("R9 half0 unaffected", 1, 1, 13'h0001);

        // R12 write and latch-trigger fetch in the same cycle
        @(negedge clk);
        gran_sel = 2'd1; latch_mode = 1; ppu_addr = 13'h0FD8; ppu_rd = 1;
        reg_wr = 1; reg_hi = 0; reg_sel = 3'd2; reg_data = 8'h9E;
        #1;
        chk("R12 same-cycle old r2/old latch", chr_addr, model(1, 1, 13'h0FD8));
        @(negedge clk);
        ppu_rd = 0; reg_wr = 0;
        m[2][7:0] = 8'h9E; lat[0] = 0;
        ppu_addr = 13'h0100;
        #1;
        chk("R12/R9 next cycle r0", chr_addr, (26'(m[0]) << 12) | 26'h100);
        fetch(13'h0FE8);
        look("R12 new r2 visible", 1, 1, 13'h0100);
        chk("R12 new r2 value", chr_addr, (26'(m[2]) << 12) | 26'h100);

        // masks
        and_mask = 16'h000F; or_mask = 16'h0130;
        look("R4 masks 8K", 0, 0, 13'h0042);
        look("R7 masks 1K", 3, 0, 13'h17FF);
        look("R6 masks 2K", 2, 0, 13'h1801);
        and_mask = 16'hFFFF; or_mask = 16'h0000;

        // R11 write enable
        @(negedge clk); ppu_wr = 1; ram_wprot = 0; #1;
        chk("R11 we open", 26'(chr_we), 26'd1);
        @(negedge clk); ram_wprot = 1; #1;
        chk("R11 we blocked", 26'(chr_we), 26'd0);
        @(negedge clk); ppu_wr = 0; ram_wprot = 0; #1;
        chk("R11 no write", 26'(chr_we), 26'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule